// File: doc/BRIEF.md
# Four-Phase Accumulator Processor

This block is a very small processor core built around one accumulator. Each word is seven bits wide. The upper three bits choose the operation, and the lower four bits name a location in a sixteen-word memory. The memory sits outside the core. The core reaches it through an address output, a read-data input, a write-data output and a write strobe. A read returns data in the same cycle, with no wait states.

Every instruction takes exactly four clock cycles.

- The first fetch phase copies the program counter into the address register.
- The second fetch phase captures the addressed word and advances the counter.
- A decode phase splits the word into opcode and operand address.
- A single execute phase performs the operation.

Programs are formed from the following instructions:

- memory loads into the accumulator or into one general register;
- a store of the accumulator;
- a jump that is taken only while the accumulator is nonzero;
- four register-to-register operations that combine the general register into the accumulator.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held, the core drives `mem_addr` to 0 and keeps `mem_we` low. After reset is released, the first instruction is fetched from address 0, and both the accumulator and the general register start at 0.
- R2: Each instruction takes four cycles: fetch-1, fetch-2, decode, execute. The program counter advances by one in fetch-2, modulo 16, so execution after address 15 continues at address 0.
- R3: Opcode 000 (word bits 6..4) loads the accumulator from the memory word whose address is given by bits 3..0.
- R4: Opcode 001 writes the accumulator to the addressed word. `mem_we` is high for exactly one clock per store, and never outside a store.
- R5: Opcode 010 loads the general register from the addressed word.
- R6: Opcode 011 sets the program counter to bits 3..0 when the accumulator is nonzero. Otherwise execution continues with the next word.
- R7: Opcode 100 sets the accumulator to (accumulator + general register) mod 128.
- R8: Opcode 101 sets the accumulator to (accumulator - general register) mod 128.
- R9: Opcode 110 sets the accumulator to the bitwise OR of the accumulator and the general register.
- R10: Opcode 111 sets the accumulator to the bitwise AND of the accumulator and the general register.
- R11: For opcodes 100 to 111, bits 3..0 of the word are ignored. The result does not depend on them, and no memory write takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the core |
| mem_addr | output | 4 | Memory address, taken from the address register |
| mem_rdata | input | 7 | Word read from `mem_addr`, valid in the same cycle |
| mem_wdata | output | 7 | Accumulator value to be stored |
| mem_we | output | 1 | Write strobe, high for one clock during a store |

## Verification
The four register operations are swept over a grid of operand pairs covering all seven bits, plus the wrap corners 127+1, 0-1 and 127-127. Each pair uses a different operand-address field, so that a result that depended on those ignored bits would show up. The conditional jump is tried with every accumulator value from 0 to 127. The taken path and the fall-through path store different values, so the single zero value is told apart from the nonzero ones. A looping program that runs off address 15 and increments a memory word on each pass shows that the counter wraps. A store issued right after reset shows that the accumulator and general register start at zero, even though the program before the reset left them nonzero.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_LDA = 3'b000,
    OP_STA = 3'b001,
    OP_LDR = 3'b010,
    OP_JNZ = 3'b011,
    OP_ADD = 3'b100,
    OP_SUB = 3'b101,
    OP_IOR = 3'b110,
    OP_AND = 3'b111
  } opcode_e;

  typedef enum logic [1:0] {
    ST_F1  = 2'd0,
    ST_F2  = 2'd1,
    ST_DEC = 2'd2,
    ST_EXE = 2'd3
  } phase_e;
endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_q = chain[STAGES-1];
endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_cpu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase
);
  phase_e phase_d;

  always_comb begin
    unique case (phase)
      ST_F1:   phase_d = ST_F2;
      ST_F2:   phase_d = ST_DEC;
      ST_DEC:  phase_d = ST_EXE;
      default: phase_d = ST_F1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= ST_F1;
    else        phase <= phase_d;
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 7
) (
  input  opcode_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_IOR:  y = a | b;
      OP_AND:  y = a & b;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int AW = 4,
  localparam int DW = OPW + AW
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we
);
  logic          rst_q;
  phase_e        phase;
  logic [AW-1:0] pc, pc_d, ar, ar_d;
  logic [DW-1:0] dr, ac, ac_d, r_q, alu_y;
  opcode_e       ir;
  logic          pc_en, ar_en, dr_en, ir_en, ac_en, r_en;
  logic          in_exe, ac_nz;

  acc_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));
  acc_seq u_seq (.clk(clk), .rst_n(rst_q), .phase(phase));
  acc_alu #(.DW(DW)) u_alu (.op(ir), .a(ac), .b(r_q), .y(alu_y));

  assign in_exe = (phase == ST_EXE);
  assign ac_nz  = |ac;

  // Next-state and enable decode
  always_comb begin
    ar_en = (phase == ST_F1) || (phase == ST_DEC);
    ar_d  = (phase == ST_F1) ? pc : dr[AW-1:0];

    dr_en = (phase == ST_F2);
    ir_en = (phase == ST_DEC);

    pc_en = (phase == ST_F2) || (in_exe && ir == OP_JNZ && ac_nz);
    pc_d  = (phase == ST_F2) ? pc + 1'b1 : ar;

    ac_en = in_exe && (ir == OP_LDA || ir[OPW-1]);
    ac_d  = (ir == OP_LDA) ? mem_rdata : alu_y;

    r_en  = in_exe && (ir == OP_LDR);
  end

  // Register bank
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      pc  <= '0;
      ar  <= '0;
      dr  <= '0;
      ir  <= OP_LDA;
      ac  <= '0;
      r_q <= '0;
    end else begin
      if (pc_en) pc  <= pc_d;
      if (ar_en) ar  <= ar_d;
      if (dr_en) dr  <= mem_rdata;
      if (ir_en) ir  <= opcode_e'(dr[DW-1:AW]);
      if (ac_en) ac  <= ac_d;
      if (r_en)  r_q <= mem_rdata;
    end
  end

  assign mem_addr  = ar;
  assign mem_wdata = ac;
  assign mem_we    = in_exe && (ir == OP_STA);
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int AW = 4,
  localparam int DW = OPW + AW
) (
  input logic          clk,
  input logic          rst_ni,
  input phase_e        phase,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] ar,
  input logic [DW-1:0] ac,
  input logic [DW-1:0] r_q,
  input opcode_e       ir,
  input logic          mem_we
);
  // R2
  f1_to_f2_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    phase == ST_F1 |=> phase == ST_F2 && ar == $past(pc));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    phase == ST_F2 |=> pc == AW'($past(pc) + 1'b1));

  // R2
  exe_return_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    phase == ST_EXE |=> phase == ST_F1);

  // R4
  store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_we |=> !mem_we);

  // R6
  jump_taken_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase == ST_EXE && ir == OP_JNZ && ac != '0) |=> pc == $past(ar));

  // R6
  jump_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase == ST_EXE && ir == OP_JNZ && ac == '0) |=> $stable(pc));

  // R7
  add_wrap_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase == ST_EXE && ir == OP_ADD) |=> ac == DW'($past(ac) + $past(r_q)));

  // R11
  reg_op_no_write_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase == ST_EXE && ir[OPW-1]) |-> !mem_we);
endmodule

bind acc_cpu acc_cpu_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_ni(rst_q), .phase(phase), .pc(pc), .ar(ar),
  .ac(ac), .r_q(r_q), .ir(ir), .mem_we(mem_we)
);

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;
  localparam int CLK_P = 10;
  localparam int AW = 4;
  localparam int DW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata, mem_wdata;
  logic          mem_we;

  logic [DW-1:0] mem [16];
  logic [DW-1:0] img [16];
  logic          ld_en = 1'b0;
  int            wr_cnt;
  int            ntests = 0;
  int            nfail = 0;
  bit            done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  acc_cpu #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (ld_en) begin
      for (int i = 0; i < 16; i++) mem[i] <= img[i];
      wr_cnt <= 0;
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic fill_img();
    for (int i = 0; i < 16; i++) img[i] = 7'h2E;
  endtask

  // Load image under reset, release, run ncyc clock edges.
  task automatic run(input int ncyc);
    @(negedge clk);
    rst_n = 1'b0;
    ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (ncyc) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic alu_case(input int op, input int a, input int b);
    int expv;
    case (op)
      4: expv = (a + b) & 127;
      5: expv = (a - b) & 127;
      6: expv = a | b;
      default: expv = a & b;
    endcase
    fill_img();
    img[0]  = 7'h0D;
    img[1]  = 7'h2E;
    img[2]  = DW'((op << 4) | (b & 15));
    img[3]  = 7'h1F;
    img[4]  = 7'h34;
    img[13] = DW'(a);
    img[14] = DW'(b);
    img[15] = DW'(~expv);
    run(20);
    case (op)
      4: chk("R7 add", int'(mem[15]), expv);
      5: chk("R8 sub", int'(mem[15]), expv);
      6: chk("R9 or", int'(mem[15]), expv);
      default: chk("R10 and", int'(mem[15]), expv);
    endcase
    chk("R11 no write from register op", wr_cnt, 1);
  endtask

  initial begin
    fill_img();
    // R1: outputs while reset held
    @(negedge clk); @(negedge clk);
    chk("R1 addr in reset", int'(mem_addr), 0);
    chk("R1 we in reset", int'(mem_we), 0);

    // R7 R8 R9 R10 R11: operand sweeps and wrap corners (R3 R5 load the operands)
    for (int op = 4; op < 8; op++) begin
      for (int a = 0; a < 128; a += 9)
        for (int b = 0; b < 128; b += 11)
          alu_case(op, a, b);
      alu_case(op, 127, 1);
      alu_case(op, 0, 1);
      alu_case(op, 127, 127);
    end

    // R1: AC and R cleared by reset (previous run left them nonzero)
    fill_img();
    img[0]  = 7'h4A;
    img[1]  = 7'h1F;
    img[15] = 7'h7F;
    run(12);
    chk("R1 AC and R zero after reset", int'(mem[15]), 0);
    chk("R4 single write", wr_cnt, 1);

    // R6 R3 R4: jump for every accumulator value
    for (int v = 0; v < 128; v++) begin
      fill_img();
      img[0]  = 7'h0D;
      img[1]  = 7'h35;
      img[2]  = 7'h0E;
      img[3]  = 7'h1F;
      img[4]  = 7'h34;
      img[5]  = 7'h1F;
      img[6]  = 7'h36;
      img[13] = DW'(v);
      img[14] = 7'h55;
      img[15] = 7'h00;
      run(24);
      chk("R6 jump", int'(mem[15]), (v != 0) ? v : 7'h55);
      chk("R4 one strobe per store", wr_cnt, 1);
    end

    // R2: counter wraps from 15 to 0; loop bumps word 12 three times
    fill_img();
    img[0]  = 7'h0C;
    img[1]  = 7'h2B;
    img[2]  = 7'h40;
    img[3]  = 7'h1C;
    img[4]  = 7'h3F;
    img[15] = 7'h1A;
    img[10] = 7'h00;
    img[11] = 7'h01;
    img[12] = 7'h00;
    run(76);
    chk("R2 wrap loop count", int'(mem[12]), 3);
    chk("R2 store at 15 ran", int'(mem[10]), 3);
    chk("R4 store count", wr_cnt, 6);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      ntests++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end
endmodule